// File: doc/BRIEF.md
# Two-Bank DRAM Controller with CAS-before-RAS Refresh

This block sits between a simple processor-side request bus and up to two banks of 16-bit-wide asynchronous DRAM. One bank answers accesses that a chip-select decoder flags as falling in the low memory region, the other answers accesses flagged as falling in the upper region. Each bank has its own enable and its own RAS pin. The byte CAS strobes, output-enable and write-enable are shared. The processor address goes out on a 9-pin multiplexed DRAM address bus. The row phase carries the odd address bits and the column phase carries the even ones.

An access holds `cpu_req` high until `cpu_rdy` pulses for one clock. The column phase can be stretched by 0 to 2 wait states to suit the speed grade of the DRAM. A refresh interval timer outside the block raises `rfsh_req`. When refresh is enabled, the block runs a fixed 7-clock CAS-before-RAS refresh on every enabled bank. A refresh never cuts into an access that has started, and it is served before the next access.

Top module: `dram2_ctrl`

## Requirements
- R1: An access with `sel_lo` drives only `dram_ras_n[0]` low, and an access with `sel_hi` drives only `dram_ras_n[1]` low.
- R2: An access to a disabled bank, or to a bank whose `bank_wide` bit is 0 (8-bit), starts no DRAM cycle. All strobes stay high and `cpu_rdy` stays low.
- R3: During the row phase (RAS low, CAS high), `dram_ma[i]` equals address bit 2i+1, i.e. A1, A3, ... A17.
- R4: During the column phase, `dram_ma[i]` equals address bit 2i+2, i.e. A2, A4, ... A18.
- R5: A read asserts both CAS strobes. On a write, `dram_ucas_n` is low only if `cpu_bhe_n` is 0, and `dram_lcas_n` is low only if address bit 0 is 0.
- R6: `dram_oe_n` is low during the column phase of a read, and `dram_we_n` is low during the column phase of a write. The two are never low together.
- R7: The row phase lasts 1 clock. The column phase lasts 1 + W clocks, where W = `wait_cfg` for values 0..2 and a `wait_cfg` of 3 acts as 2.
- R8: A refresh lasts exactly 7 clocks. In clock 1 both CAS strobes are low with RAS high. In clocks 2 to 5 both CAS strobes stay low and RAS is low on every enabled bank. Clocks 6 and 7 are all high. Refresh requests are ignored while `rfsh_en` is 0 or when no bank is enabled.
- R9: A refresh request that arrives during an access waits until that access ends. A pending refresh is served before a waiting access.
- R10: `cpu_rdy` is low for the whole access, including wait states and any refresh stall. It goes high for exactly one clock, the clock after the last column clock, with all strobes high.
- R11: Every RAS pin stays high for at least 2 clocks before it falls again.
- R12: After reset all strobes are high, `dram_ma` is 0 and `cpu_rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_rdy` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 19 | Processor byte address A18..A0 |
| cpu_bhe_n | input | 1 | Byte-high enable, active low |
| sel_lo | input | 1 | Access falls in the low region |
| sel_hi | input | 1 | Access falls in the upper region |
| bank_en | input | 2 | Bank enables, bit 0 low bank, bit 1 upper bank |
| bank_wide | input | 2 | 1 = bank configured 16-bit |
| wait_cfg | input | 2 | Wait states for the column phase |
| rfsh_en | input | 1 | Refresh enable |
| rfsh_req | input | 1 | Refresh request pulse from interval timer |
| cpu_rdy | output | 1 | One-clock access-complete pulse |
| dram_ma | output | 9 | Multiplexed DRAM address |
| dram_ras_n | output | 2 | RAS per bank, active low |
| dram_ucas_n | output | 1 | CAS for data bits 15..8, active low |
| dram_lcas_n | output | 1 | CAS for data bits 7..0, active low |
| dram_oe_n | output | 1 | DRAM output enable, active low |
| dram_we_n | output | 1 | DRAM write enable, active low |

## Verification
The bench goes after the byte-lane choices on writes. A swapped or inverted lane test would corrupt the neighbouring byte. It also exercises every wait setting, including the clamped value 3, because an off-by-one there shifts `cpu_rdy` and breaks the reference comparison. Refresh requests are raised together with an access and also in the middle of one. Serving them late would starve refresh, and serving them early would tear an open row. Accesses to disabled and 8-bit banks, and refresh with refresh or every bank disabled, must leave the pins idle. A design that started a cycle there would drive a RAS pin with nothing behind it.

// File: rtl/dram2_pkg.sv
package dram2_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_CAS,
        ST_END,
        ST_REF
    } dram_st_e;

    typedef struct packed {
        dram_st_e    st;
        logic [2:0]  cnt;
        logic        bank;
        logic        wr;
        logic [8:0]  col;
        logic        ucas_en;
        logic        lcas_en;
        logic [1:0]  ras_n;
        logic        ucas_n;
        logic        lcas_n;
        logic        oe_n;
        logic        we_n;
        logic [8:0]  ma;
        logic        rdy;
    } dram_ctl_s;

endpackage

// File: rtl/dram2_addr_mux.sv
module dram2_addr_mux #(
    parameter int NPIN = 9
) (
    input  logic [2*NPIN-1:0] addr_hi,
    output logic [NPIN-1:0]   row_addr,
    output logic [NPIN-1:0]   col_addr
);
    // addr_hi[k] is processor bit k+1
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign row_addr[i] = addr_hi[2*i];
        assign col_addr[i] = addr_hi[2*i+1];
    end
endmodule

// File: rtl/dram2_byte_lanes.sv
module dram2_byte_lanes (
    input  logic wr,
    input  logic bhe_n,
    input  logic a0,
    output logic ucas_en,
    output logic lcas_en
);
    always_comb begin
        ucas_en = !wr || !bhe_n;
        lcas_en = !wr || !a0;
    end
endmodule

// File: rtl/dram2_bank_sel.sv
module dram2_bank_sel #(
    parameter int NBANK = 2
) (
    input  logic             req,
    input  logic             sel_lo,
    input  logic             sel_hi,
    input  logic [NBANK-1:0] bank_en,
    input  logic [NBANK-1:0] bank_wide,
    output logic             go,
    output logic             go_bank
);
    logic [NBANK-1:0] usable;
    logic             hit_lo;
    logic             hit_hi;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign usable[b] = bank_en[b] && bank_wide[b];
    end

    always_comb begin
        hit_lo  = sel_lo && usable[0];
        hit_hi  = sel_hi && usable[NBANK-1];
        go      = req && (hit_lo || hit_hi);
        go_bank = !hit_lo;
    end
endmodule

// File: rtl/dram2_ref_arb.sv
module dram2_ref_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_req,
    input  logic rfsh_en,
    input  logic any_en,
    input  logic take,
    output logic pend
);
    logic pend_d, pend_q;
    logic arrive;

    always_comb begin
        arrive = rfsh_req && rfsh_en && any_en;
        pend   = (pend_q || arrive) && rfsh_en && any_en;
        pend_d = pend && !take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/dram2_ctrl.sv
module dram2_ctrl
    import dram2_pkg::*;
#(
    parameter int NPIN   = 9,
    parameter int WS_MAX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [2*NPIN:0]   cpu_addr,
    input  logic              cpu_bhe_n,
    input  logic              sel_lo,
    input  logic              sel_hi,
    input  logic [1:0]        bank_en,
    input  logic [1:0]        bank_wide,
    input  logic [1:0]        wait_cfg,
    input  logic              rfsh_en,
    input  logic              rfsh_req,
    output logic              cpu_rdy,
    output logic [NPIN-1:0]   dram_ma,
    output logic [1:0]        dram_ras_n,
    output logic              dram_ucas_n,
    output logic              dram_lcas_n,
    output logic              dram_oe_n,
    output logic              dram_we_n
);
    localparam int NBANK      = 2;
    localparam int REF_CLKS   = 7;
    localparam int REF_LAST   = REF_CLKS - 1;
    localparam int REF_RAS_LO = 1;
    localparam int REF_RAS_HI = REF_CLKS - 3;

    dram_ctl_s d, q;

    logic [NPIN-1:0] row_addr, col_addr;
    logic            ucas_en, lcas_en;
    logic            go, go_bank;
    logic            ref_pend, ref_take;
    logic [2:0]      ws_eff;

    dram2_addr_mux #(.NPIN(NPIN)) u_mux (
        .addr_hi  (cpu_addr[2*NPIN:1]),
        .row_addr (row_addr),
        .col_addr (col_addr)
    );

    dram2_byte_lanes u_lanes (
        .wr      (cpu_wr),
        .bhe_n   (cpu_bhe_n),
        .a0      (cpu_addr[0]),
        .ucas_en (ucas_en),
        .lcas_en (lcas_en)
    );

    dram2_bank_sel #(.NBANK(NBANK)) u_sel (
        .req       (cpu_req),
        .sel_lo    (sel_lo),
        .sel_hi    (sel_hi),
        .bank_en   (bank_en),
        .bank_wide (bank_wide),
        .go        (go),
        .go_bank   (go_bank)
    );

    dram2_ref_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rfsh_req (rfsh_req),
        .rfsh_en  (rfsh_en),
        .any_en   (|bank_en),
        .take     (ref_take),
        .pend     (ref_pend)
    );

    always_comb begin
        ws_eff = (int'(wait_cfg) > WS_MAX) ? 3'(WS_MAX) : {1'b0, wait_cfg};
    end

    always_comb begin
        d        = q;
        ref_take = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    d.st     = ST_REF;
                    d.cnt    = '0;
                    ref_take = 1'b1;
                end else if (go) begin
                    d.st      = ST_ROW;
                    d.bank    = go_bank;
                    d.wr      = cpu_wr;
                    d.col     = col_addr;
                    d.ucas_en = ucas_en;
                    d.lcas_en = lcas_en;
                    d.ma      = row_addr;
                end
            end
            ST_ROW: begin
                d.st  = ST_CAS;
                d.cnt = ws_eff;
                d.ma  = q.col;
            end
            ST_CAS: begin
                if (q.cnt == '0) d.st  = ST_END;
                else             d.cnt = q.cnt - 3'd1;
            end
            ST_END: d.st = ST_IDLE;
            ST_REF: begin
                if (int'(q.cnt) == REF_LAST) d.st  = ST_IDLE;
                else                         d.cnt = q.cnt + 3'd1;
            end
            default: d.st = ST_IDLE;
        endcase

        // pin values for the state being entered
        d.ras_n  = '1;
        d.ucas_n = 1'b1;
        d.lcas_n = 1'b1;
        d.oe_n   = 1'b1;
        d.we_n   = 1'b1;
        d.rdy    = 1'b0;
        case (d.st)
            ST_ROW: d.ras_n[d.bank] = 1'b0;
            ST_CAS: begin
                d.ras_n[d.bank] = 1'b0;
                d.ucas_n        = !d.ucas_en;
                d.lcas_n        = !d.lcas_en;
                d.oe_n          = d.wr;
                d.we_n          = !d.wr;
            end
            ST_END: begin
                d.rdy = 1'b1;
                d.ma  = '0;
            end
            ST_REF: begin
                d.ma = '0;
                if (int'(d.cnt) <= REF_RAS_HI) begin
                    d.ucas_n = 1'b0;
                    d.lcas_n = 1'b0;
                end
                if (int'(d.cnt) >= REF_RAS_LO && int'(d.cnt) <= REF_RAS_HI)
                    d.ras_n = ~bank_en;
            end
            default: d.ma = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.ras_n  <= '1;
            q.ucas_n <= 1'b1;
            q.lcas_n <= 1'b1;
            q.oe_n   <= 1'b1;
            q.we_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cpu_rdy     = q.rdy;
    assign dram_ma     = q.ma;
    assign dram_ras_n  = q.ras_n;
    assign dram_ucas_n = q.ucas_n;
    assign dram_lcas_n = q.lcas_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_we_n   = q.we_n;
endmodule

// File: rtl/dram2_ctrl_chk.sv
module dram2_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_rdy,
    input logic [1:0] dram_ras_n,
    input logic       dram_ucas_n,
    input logic       dram_lcas_n,
    input logic       dram_oe_n,
    input logic       dram_we_n
);
    logic [1:0] hi_cnt [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt[0] <= 2'd3;
            hi_cnt[1] <= 2'd3;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (!dram_ras_n[b])          hi_cnt[b] <= 2'd0;
                else if (hi_cnt[b] != 2'd3)  hi_cnt[b] <= hi_cnt[b] + 2'd1;
            end
        end
    end

    AST_ONE_BANK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_oe_n || !dram_we_n) |-> ($countones(~dram_ras_n) == 1)); // R1

    AST_READ_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (!dram_ucas_n && !dram_lcas_n)); // R5

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_oe_n && !dram_we_n)); // R6

    AST_CBR_ORDER0: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n[0]) && !dram_ucas_n) |-> $past(!dram_ucas_n && !dram_lcas_n)); // R8

    AST_CBR_ORDER1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n[1]) && !dram_ucas_n) |-> $past(!dram_ucas_n && !dram_lcas_n)); // R8

    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |=> !cpu_rdy); // R10

    AST_RDY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> (dram_ras_n == 2'b11 && dram_ucas_n && dram_lcas_n)); // R10

    AST_PRECHARGE0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n[0]) |-> (hi_cnt[0] >= 2'd2)); // R11

    AST_PRECHARGE1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n[1]) |-> (hi_cnt[1] >= 2'd2)); // R11
endmodule

bind dram2_ctrl dram2_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rdy     (cpu_rdy),
    .dram_ras_n  (dram_ras_n),
    .dram_ucas_n (dram_ucas_n),
    .dram_lcas_n (dram_lcas_n),
    .dram_oe_n   (dram_oe_n),
    .dram_we_n   (dram_we_n)
);

// File: tb/tb_dram2_ctrl.sv
module tb_dram2_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_wr = 1'b0, cpu_bhe_n = 1'b1;
    logic [18:0] cpu_addr = '0;
    logic        sel_lo = 1'b0, sel_hi = 1'b0;
    logic [1:0]  bank_en = 2'b11, bank_wide = 2'b11, wait_cfg = 2'd0;
    logic        rfsh_en = 1'b1, rfsh_req = 1'b0;
    logic        cpu_rdy;
    logic [8:0]  dram_ma;
    logic [1:0]  dram_ras_n;
    logic        dram_ucas_n, dram_lcas_n, dram_oe_n, dram_we_n;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dram2_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_bhe_n(cpu_bhe_n), .sel_lo(sel_lo),
        .sel_hi(sel_hi), .bank_en(bank_en), .bank_wide(bank_wide),
        .wait_cfg(wait_cfg), .rfsh_en(rfsh_en), .rfsh_req(rfsh_req),
        .cpu_rdy(cpu_rdy), .dram_ma(dram_ma), .dram_ras_n(dram_ras_n),
        .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
        .dram_oe_n(dram_oe_n), .dram_we_n(dram_we_n)
    );

    // expected pin vector: {rdy, ras_n[1:0], ucas_n, lcas_n, oe_n, we_n, ma[8:0]}
    function automatic logic [15:0] pins_now();
        return {cpu_rdy, dram_ras_n, dram_ucas_n, dram_lcas_n, dram_oe_n, dram_we_n, dram_ma};
    endfunction

    function automatic logic [15:0] idle_vec();
        return {1'b0, 2'b11, 4'b1111, 9'd0};
    endfunction

    function automatic logic [8:0] odd_bits(input logic [18:0] a);
        logic [8:0] r;
        for (int i = 0; i < 9; i++) r[i] = a[2*i+1];
        return r;
    endfunction

    function automatic logic [8:0] even_bits(input logic [18:0] a);
        logic [8:0] r;
        for (int i = 0; i < 9; i++) r[i] = a[2*i+2];
        return r;
    endfunction

    function automatic logic [15:0] ref_vec(input int k, input logic [1:0] en);
        logic [1:0] ras;
        logic       cas;
        cas = (k <= 4) ? 1'b0 : 1'b1;
        ras = (k >= 1 && k <= 4) ? ~en : 2'b11;
        return {1'b0, ras, cas, cas, 2'b11, 9'd0};
    endfunction

    task automatic cmp(input string tag, input logic [15:0] exp);
        logic [15:0] act;
        act = pins_now();
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic idle_for(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cmp(tag, idle_vec());
        end
    endtask

    task automatic expect_ref(input string tag);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            rfsh_req = 1'b0;
            cmp(tag, ref_vec(k, bank_en));
        end
    endtask

    // R1 R3 R4 R5 R6 R7 R10 R9 model of one access
    task automatic access(input bit hi, input bit wr, input logic [18:0] a,
                          input logic bhe_n, input logic [1:0] ws,
                          input bit ref_first, input bit ref_mid);
        logic [1:0] ras;
        logic       u, l;
        int         nw;
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_bhe_n = bhe_n;
        sel_lo = !hi; sel_hi = hi; wait_cfg = ws;
        if (ref_first) rfsh_req = 1'b1;
        if (ref_first) begin
            expect_ref("R9 refresh before access");
            @(negedge clk);
            cmp("R9 idle after refresh", idle_vec());
        end
        ras = hi ? 2'b01 : 2'b10;
        u   = wr ? bhe_n : 1'b0;
        l   = wr ? a[0]  : 1'b0;
        nw  = (ws > 2'd2) ? 2 : int'(ws);
        @(negedge clk);
        cmp("R1 R3 row phase", {1'b0, ras, 4'b1111, odd_bits(a)});
        for (int k = 0; k <= nw; k++) begin
            @(negedge clk);
            if (ref_mid && k == 0) rfsh_req = 1'b1;
            else rfsh_req = 1'b0;
            cmp("R4 R5 R6 R7 column phase",
                {1'b0, ras, u, l, wr, !wr, even_bits(a)});
        end
        @(negedge clk);
        rfsh_req = 1'b0;
        cmp("R10 ready pulse", {1'b1, 2'b11, 4'b1111, 9'd0});
        cpu_req = 1'b0; sel_lo = 1'b0; sel_hi = 1'b0;
        @(negedge clk);
        cmp("R10 ready single", idle_vec());
        if (ref_mid) expect_ref("R9 refresh after access");
    endtask

    initial begin
        #(CLK_P*20000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P*2);
        cmp("R12 reset state", idle_vec());
        @(negedge clk);
        rst_n = 1'b1;
        idle_for(2, "R12 after reset");

        access(1'b0, 1'b0, 19'h5A5A5, 1'b0, 2'd0, 1'b0, 1'b0);  // read low bank
        access(1'b1, 1'b0, 19'h2C3D7, 1'b0, 2'd1, 1'b0, 1'b0);  // read upper bank
        access(1'b0, 1'b1, 19'h13578, 1'b0, 2'd2, 1'b0, 1'b0);  // word write
        access(1'b1, 1'b1, 19'h7FFFF, 1'b0, 2'd0, 1'b0, 1'b0);  // high byte only
        access(1'b0, 1'b1, 19'h40002, 1'b1, 2'd3, 1'b0, 1'b0);  // low byte, ws clamp
        access(1'b1, 1'b1, 19'h0AAAB, 1'b1, 2'd1, 1'b0, 1'b0);  // no lane
        access(1'b0, 1'b0, 19'h7AAAA, 1'b1, 2'd2, 1'b1, 1'b0);  // refresh first
        access(1'b1, 1'b1, 19'h15554, 1'b0, 2'd1, 1'b0, 1'b1);  // refresh mid

        // R8 refresh on one bank only
        bank_en = 2'b10;
        @(negedge clk); rfsh_req = 1'b1;
        expect_ref("R8 refresh upper only");
        idle_for(1, "R8 refresh ends");
        bank_en = 2'b11;

        // R8 refresh disabled
        rfsh_en = 1'b0;
        @(negedge clk); rfsh_req = 1'b1;
        @(negedge clk); rfsh_req = 1'b0;
        cmp("R8 refresh disabled", idle_vec());
        idle_for(8, "R8 refresh disabled");
        rfsh_en = 1'b1;

        // R8 no bank enabled: refresh ignored
        bank_en = 2'b00;
        @(negedge clk); rfsh_req = 1'b1;
        @(negedge clk); rfsh_req = 1'b0;
        idle_for(8, "R8 no bank refresh");

        // R2 disabled bank access ignored
        bank_en = 2'b10;
        @(negedge clk); cpu_req = 1'b1; sel_lo = 1'b1; cpu_addr = 19'h12345;
        idle_for(6, "R2 disabled bank");
        cpu_req = 1'b0; sel_lo = 1'b0;
        bank_en = 2'b11;

        // R2 8-bit bank access ignored
        bank_wide = 2'b01;
        @(negedge clk); cpu_req = 1'b1; sel_hi = 1'b1;
        idle_for(6, "R2 narrow bank");
        cpu_req = 1'b0; sel_hi = 1'b0;
        bank_wide = 2'b11;

        // R11 back-to-back accesses to the same bank
        access(1'b0, 1'b0, 19'h00F0F, 1'b0, 2'd0, 1'b0, 1'b0);
        access(1'b0, 1'b1, 19'h3F0F1, 1'b0, 2'd0, 1'b0, 1'b0);
        idle_for(3, "R11 idle tail");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule